// File: doc/BRIEF.md
# Tiled Background Layer Fetch Address Generator

This block turns a screen beam position into the memory addresses one background layer needs to draw that pixel in tiled mode. The layer's X scroll, optionally raised by a per-line horizontal offset, and its Y scroll place the beam inside a wrapping layer plane. The block then finds the tile under the pixel and issues a read of the tile-index map. It can also issue a read of a packed per-tile attribute map. It then forms the word address of the tile pixel data and the bit position of the pixel inside that word.

The block is a three-stage pipeline. Stage one registers the map read addresses. A synchronous memory answers both reads one cycle later. Stage three combines the returned tile index and attribute word with the context carried down the pipe. It outputs the data word address, the bit offset, the palette bank, the effective mirror flags and the blend flag. A tile index of zero, a disabled layer and bitmap mode all produce a transparent result, and no data address is used for them.

Tile width and height are chosen separately from 8, 16, 32 or 64 pixels. Pixel depth is 2, 4, 6 or 8 bits. Tile pixel data is packed densely, so a 6-bit pixel may straddle two words.

Top module: `tile_fetch_agen`

## Requirements
- R1: While reset is high, and on the cycle after it, out_valid, map_rd_en and attr_rd_en are low.
- R2: One cycle after pix_valid is taken with lyr_en=1 and bmp_mode=0, map_rd_en is high and map_addr = map_base + row*(512/W) + col, modulo 8192. Here lx = (beam_x + scroll_x [+ line_xofs]) mod 512, ly = (beam_y + scroll_y) mod 256, col = lx/W and row = ly/H. W = 8<<lyr_attr[5:4] and H = 8<<lyr_attr[7:6].
- R3: line_xofs is added to lx only when line_scroll_en=1. Otherwise it has no effect on any address.
- R4: With attr_from_reg=0 the attribute map is read at attr_base + lin/2, where lin = row*(512/W)+col. An even lin selects the low byte of the returned word and an odd lin selects the high byte. In that byte, bits 3:0 are the palette bank, bit 4 mirrors horizontally, bit 5 mirrors vertically and bit 6 enables blending. attr_rd_en is never high without map_rd_en.
- R5: With attr_from_reg=1 no attribute read is issued. The palette is lyr_attr[11:8], the horizontal mirror is lyr_attr[2], the vertical mirror is lyr_attr[3] and the blend flag is blend_en.
- R6: With wallpaper=1 the attribute read address is attr_base and the low byte is used for every tile.
- R7: out_valid rises two cycles after map_rd_en (three after the accepted pix_valid). out_data_addr = tile_seg*64 + index*(W*H*bpp/16) + floor(bitpos/16), where bitpos = (ty*W + tx)*bpp.
- R8: out_bit_ofs = bitpos mod 16. lyr_attr[1:0] selects bpp as 0→2, 1→4, 2→6, 3→8. At 6 bpp a pixel may start at bit 12 or 14 and spill into the next word.
- R9: tx = lx mod W and ty = ly mod H. When the effective mirror flag is set they become W-1-tx and H-1-ty, and out_hflip and out_vflip report the flags.
- R10: A returned tile index of 0 gives out_transp=1, with out_data_addr, out_bit_ofs, palette, mirror and blend outputs all 0.
- R11: With lyr_en=0 or bmp_mode=1 no map or attribute read is issued, and the result is valid and transparent with all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | A beam position is presented this cycle |
| beam_x | input | 9 | Screen column |
| beam_y | input | 9 | Screen line |
| line_xofs | input | 9 | Per-line horizontal offset from the shared table |
| scroll_x | input | 9 | Layer horizontal scroll |
| scroll_y | input | 9 | Layer vertical scroll |
| lyr_attr | input | 12 | Depth [1:0], mirror H [2], mirror V [3], width [5:4], height [7:6], palette [11:8] |
| lyr_en | input | 1 | Layer enable |
| bmp_mode | input | 1 | Layer in bitmap mode (handled elsewhere) |
| attr_from_reg | input | 1 | Use lyr_attr for all tiles instead of the attribute map |
| wallpaper | input | 1 | Only the first tile's attribute applies |
| line_scroll_en | input | 1 | Add line_xofs to the horizontal scroll |
| blend_en | input | 1 | Blend flag used with register attributes |
| map_base | input | 13 | Tile-index map base address |
| attr_base | input | 13 | Attribute map base address |
| tile_seg | input | 16 | Tile data segment |
| map_rd_en | output | 1 | Tile-index map read strobe |
| map_addr | output | 13 | Tile-index map read address |
| map_rdata | input | 16 | Tile index, one cycle after the read |
| attr_rd_en | output | 1 | Attribute map read strobe |
| attr_addr | output | 13 | Attribute map read address |
| attr_rdata | input | 16 | Two packed tile attributes, one cycle after the read |
| out_valid | output | 1 | Result valid |
| out_transp | output | 1 | Pixel is transparent |
| out_data_addr | output | 29 | Tile pixel data word address |
| out_bit_ofs | output | 4 | First bit of the pixel in that word |
| out_pal | output | 4 | Palette bank |
| out_hflip | output | 1 | Effective horizontal mirror |
| out_vflip | output | 1 | Effective vertical mirror |
| out_blend | output | 1 | Effective blend flag |

## Verification
The hardest states to reach are the 6-bit pixels whose start bit is 12 or 14, a pixel under combined mirroring in a 64-pixel tile, and an odd-numbered tile read while wallpaper mode overrides its byte choice. Random beam positions rarely line up on these. Directed pixels are therefore placed at chosen in-tile coordinates with the tile geometry fixed. The bench memory returns a tile index computed from the read address, and a switch in it forces index zero, so that the transparent path is taken on demand. After that, constrained random configurations and positions, drawn from a fixed seed, sweep the geometry, depth and scroll wrap combinations.

// File: rtl/tfa_pkg.sv
package tfa_pkg;

    localparam int COORD_W = 9;
    localparam int MAP_AW  = 13;
    localparam int WORD_W  = 16;
    localparam int IDX_W   = 16;
    localparam int SEG_W   = 16;
    localparam int TPOS_W  = 6;
    localparam int ATTR_W  = 12;
    localparam int DATA_AW = ((SEG_W + 6 > IDX_W + 12) ? SEG_W + 6 : IDX_W + 12) + 1;

    typedef enum logic [1:0] {
        DEPTH_2 = 2'd0,
        DEPTH_4 = 2'd1,
        DEPTH_6 = 2'd2,
        DEPTH_8 = 2'd3
    } depth_e;

    typedef struct packed {
        logic [3:0] pal;
        logic       hflip;
        logic       vflip;
        logic       blend;
    } tile_attr_t;

    typedef struct packed {
        logic              live;
        logic              use_reg;
        logic              odd;
        logic [1:0]        wsel;
        logic [1:0]        hsel;
        depth_e            depth;
        logic [TPOS_W-1:0] tx;
        logic [TPOS_W-1:0] ty;
        logic [SEG_W-1:0]  seg;
        tile_attr_t        reg_attr;
    } fetch_ctx_t;

    function automatic logic [3:0] depth_bits(depth_e d);
        return {1'b0, d, 1'b0} + 4'd2;
    endfunction

    function automatic logic [TPOS_W-1:0] side_mask(logic [1:0] sel);
        return TPOS_W'((32'd8 << sel) - 32'd1);
    endfunction

    function automatic tile_attr_t attr_from_byte(logic [6:0] b);
        tile_attr_t a;
        a.pal   = b[3:0];
        a.hflip = b[4];
        a.vflip = b[5];
        a.blend = b[6];
        return a;
    endfunction

endpackage

// File: rtl/tfa_coord.sv
module tfa_coord
    import tfa_pkg::*;
#(
    parameter int PW_LOG2 = 9,
    parameter int PH_LOG2 = 8
) (
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic [COORD_W-1:0] scroll_x,
    input  logic [COORD_W-1:0] scroll_y,
    input  logic [COORD_W-1:0] line_xofs,
    input  logic               line_en,
    input  logic               wall,
    input  logic [1:0]         wsel,
    input  logic [1:0]         hsel,
    input  logic [MAP_AW-1:0]  map_base,
    input  logic [MAP_AW-1:0]  attr_base,
    output logic [MAP_AW-1:0]  map_addr,
    output logic [MAP_AW-1:0]  attr_addr,
    output logic               odd,
    output logic [TPOS_W-1:0]  tx,
    output logic [TPOS_W-1:0]  ty
);

    localparam int LIN_W = PW_LOG2 + PH_LOG2 - 6;

    logic [PW_LOG2-1:0] lx;
    logic [PH_LOG2-1:0] ly;
    logic [PW_LOG2-1:0] col;
    logic [PH_LOG2-1:0] row;
    logic [LIN_W-1:0]   lin;
    logic [COORD_W-1:0] hofs;

    always_comb begin
        hofs = line_en ? line_xofs : '0;
        lx   = PW_LOG2'({2'b00, beam_x} + {2'b00, scroll_x} + {2'b00, hofs});
        ly   = PH_LOG2'({1'b0, beam_y} + {1'b0, scroll_y});
        col  = lx >> (32'd3 + 32'(wsel));
        row  = ly >> (32'd3 + 32'(hsel));
        lin  = LIN_W'(LIN_W'(row) << (PW_LOG2 - 3 - int'(wsel))) + LIN_W'(col);
        tx   = lx[TPOS_W-1:0] & side_mask(wsel);
        ty   = ly[TPOS_W-1:0] & side_mask(hsel);
        map_addr  = map_base + MAP_AW'(lin);
        attr_addr = wall ? attr_base : attr_base + MAP_AW'(lin >> 1);
        odd       = !wall && lin[0];
    end

endmodule

// File: rtl/tfa_attr_sel.sv
module tfa_attr_sel
    import tfa_pkg::*;
(
    input  logic              use_reg,
    input  logic              odd,
    input  logic [WORD_W-1:0] attr_word,
    input  tile_attr_t        reg_attr,
    output tile_attr_t        attr
);

    logic [6:0] pick;
    logic       unused_top_bits;

    assign unused_top_bits = attr_word[15] ^ attr_word[7];

    always_comb begin
        pick = odd ? attr_word[14:8] : attr_word[6:0];
        attr = use_reg ? reg_attr : attr_from_byte(pick);
    end

endmodule

// File: rtl/tfa_data_addr.sv
module tfa_data_addr
    import tfa_pkg::*;
(
    input  logic [SEG_W-1:0]   seg,
    input  logic [IDX_W-1:0]   idx,
    input  logic [1:0]         wsel,
    input  logic [1:0]         hsel,
    input  depth_e             depth,
    input  logic [TPOS_W-1:0]  tx,
    input  logic [TPOS_W-1:0]  ty,
    input  logic               hflip,
    input  logic               vflip,
    output logic [DATA_AW-1:0] word_addr,
    output logic [3:0]         bit_ofs
);

    logic [TPOS_W-1:0] fx;
    logic [TPOS_W-1:0] fy;
    logic [11:0]       pix;
    logic [15:0]       bitpos;
    logic [15:0]       size_words;
    logic [3:0]        bpp;

    always_comb begin
        bpp        = depth_bits(depth);
        fx         = hflip ? side_mask(wsel) - tx : tx;
        fy         = vflip ? side_mask(hsel) - ty : ty;
        pix        = 12'({6'b0, fy} << (32'd3 + 32'(wsel))) + {6'b0, fx};
        bitpos     = {4'b0, pix} * {12'b0, bpp};
        size_words = {12'b0, bpp} << (32'd2 + 32'(wsel) + 32'(hsel));
        word_addr  = DATA_AW'({seg, 6'b0})
                   + DATA_AW'(idx) * DATA_AW'(size_words)
                   + DATA_AW'(bitpos[15:4]);
        bit_ofs    = bitpos[3:0];
    end

endmodule

// File: rtl/tile_fetch_agen.sv
module tile_fetch_agen
    import tfa_pkg::*;
#(
    parameter int PW_LOG2 = 9,
    parameter int PH_LOG2 = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    input  logic [8:0]         beam_x,
    input  logic [8:0]         beam_y,
    input  logic [8:0]         line_xofs,
    input  logic [8:0]         scroll_x,
    input  logic [8:0]         scroll_y,
    input  logic [11:0]        lyr_attr,
    input  logic               lyr_en,
    input  logic               bmp_mode,
    input  logic               attr_from_reg,
    input  logic               wallpaper,
    input  logic               line_scroll_en,
    input  logic               blend_en,
    input  logic [12:0]        map_base,
    input  logic [12:0]        attr_base,
    input  logic [15:0]        tile_seg,
    output logic               map_rd_en,
    output logic [12:0]        map_addr,
    input  logic [15:0]        map_rdata,
    output logic               attr_rd_en,
    output logic [12:0]        attr_addr,
    input  logic [15:0]        attr_rdata,
    output logic               out_valid,
    output logic               out_transp,
    output logic [28:0]        out_data_addr,
    output logic [3:0]         out_bit_ofs,
    output logic [3:0]         out_pal,
    output logic               out_hflip,
    output logic               out_vflip,
    output logic               out_blend
);

    logic [MAP_AW-1:0] c_map_addr;
    logic [MAP_AW-1:0] c_attr_addr;
    logic              c_odd;
    logic [TPOS_W-1:0] c_tx;
    logic [TPOS_W-1:0] c_ty;
    logic              fetch_go;
    fetch_ctx_t        ctx_new;

    fetch_ctx_t        ctx1;
    fetch_ctx_t        ctx2;
    logic              v1;
    logic              v2;

    tile_attr_t        sel_attr;
    logic [DATA_AW-1:0] c_data_addr;
    logic [3:0]        c_bit_ofs;
    logic              c_transp;

    tfa_coord #(
        .PW_LOG2(PW_LOG2),
        .PH_LOG2(PH_LOG2)
    ) u_coord (
        .beam_x   (beam_x),
        .beam_y   (beam_y),
        .scroll_x (scroll_x),
        .scroll_y (scroll_y),
        .line_xofs(line_xofs),
        .line_en  (line_scroll_en),
        .wall     (wallpaper),
        .wsel     (lyr_attr[5:4]),
        .hsel     (lyr_attr[7:6]),
        .map_base (map_base),
        .attr_base(attr_base),
        .map_addr (c_map_addr),
        .attr_addr(c_attr_addr),
        .odd      (c_odd),
        .tx       (c_tx),
        .ty       (c_ty)
    );

    always_comb begin
        fetch_go               = pix_valid && lyr_en && !bmp_mode;
        ctx_new.live           = lyr_en && !bmp_mode;
        ctx_new.use_reg        = attr_from_reg;
        ctx_new.odd            = c_odd;
        ctx_new.wsel           = lyr_attr[5:4];
        ctx_new.hsel           = lyr_attr[7:6];
        ctx_new.depth          = depth_e'(lyr_attr[1:0]);
        ctx_new.tx             = c_tx;
        ctx_new.ty             = c_ty;
        ctx_new.seg            = tile_seg;
        ctx_new.reg_attr.pal   = lyr_attr[11:8];
        ctx_new.reg_attr.hflip = lyr_attr[2];
        ctx_new.reg_attr.vflip = lyr_attr[3];
        ctx_new.reg_attr.blend = blend_en;
    end

    // Stage 1: issue map reads and capture context
    always_ff @(posedge clk) begin
        if (rst) begin
            v1         <= 1'b0;
            map_rd_en  <= 1'b0;
            attr_rd_en <= 1'b0;
            map_addr   <= '0;
            attr_addr  <= '0;
            ctx1       <= '0;
        end else begin
            v1         <= pix_valid;
            map_rd_en  <= fetch_go;
            attr_rd_en <= fetch_go && !attr_from_reg;
            if (pix_valid) begin
                map_addr  <= c_map_addr;
                attr_addr <= c_attr_addr;
                ctx1      <= ctx_new;
            end
        end
    end

    // Stage 2: wait for the memory answer
    always_ff @(posedge clk) begin
        if (rst) begin
            v2   <= 1'b0;
            ctx2 <= '0;
        end else begin
            v2   <= v1;
            ctx2 <= ctx1;
        end
    end

    tfa_attr_sel u_attr_sel (
        .use_reg  (ctx2.use_reg),
        .odd      (ctx2.odd),
        .attr_word(attr_rdata),
        .reg_attr (ctx2.reg_attr),
        .attr     (sel_attr)
    );

    tfa_data_addr u_data_addr (
        .seg      (ctx2.seg),
        .idx      (map_rdata),
        .wsel     (ctx2.wsel),
        .hsel     (ctx2.hsel),
        .depth    (ctx2.depth),
        .tx       (ctx2.tx),
        .ty       (ctx2.ty),
        .hflip    (sel_attr.hflip),
        .vflip    (sel_attr.vflip),
        .word_addr(c_data_addr),
        .bit_ofs  (c_bit_ofs)
    );

    assign c_transp = !ctx2.live || (map_rdata == '0);

    // Stage 3: result register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_transp    <= 1'b0;
            out_data_addr <= '0;
            out_bit_ofs   <= '0;
            out_pal       <= '0;
            out_hflip     <= 1'b0;
            out_vflip     <= 1'b0;
            out_blend     <= 1'b0;
        end else begin
            out_valid <= v2;
            if (v2) begin
                out_transp <= c_transp;
                if (c_transp) begin
                    out_data_addr <= '0;
                    out_bit_ofs   <= '0;
                    out_pal       <= '0;
                    out_hflip     <= 1'b0;
                    out_vflip     <= 1'b0;
                    out_blend     <= 1'b0;
                end else begin
                    out_data_addr <= c_data_addr;
                    out_bit_ofs   <= c_bit_ofs;
                    out_pal       <= sel_attr.pal;
                    out_hflip     <= sel_attr.hflip;
                    out_vflip     <= sel_attr.vflip;
                    out_blend     <= sel_attr.blend;
                end
            end
        end
    end

endmodule

// File: rtl/tfa_chk.sv
module tfa_chk (
    input logic        clk,
    input logic        rst,
    input logic        pix_valid,
    input logic        lyr_en,
    input logic        bmp_mode,
    input logic        attr_from_reg,
    input logic        map_rd_en,
    input logic        attr_rd_en,
    input logic [15:0] map_rdata,
    input logic        out_valid,
    input logic        out_transp,
    input logic [28:0] out_data_addr,
    input logic [3:0]  out_bit_ofs
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && !map_rd_en && !attr_rd_en)); // R1

    AST_MAP_READ_ISSUED: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && lyr_en && !bmp_mode) |=> map_rd_en); // R2

    AST_ATTR_NEEDS_MAP: assert property (@(posedge clk) disable iff (rst)
        attr_rd_en |-> map_rd_en); // R4

    AST_REG_ATTR_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && attr_from_reg) |=> !attr_rd_en); // R5

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> ##3 out_valid); // R7

    AST_ZERO_INDEX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(map_rd_en) && map_rdata == 16'd0) |=>
        (out_valid && out_transp && out_data_addr == 29'd0 && out_bit_ofs == 4'd0)); // R10

    AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && (!lyr_en || bmp_mode)) |=> (!map_rd_en && !attr_rd_en)); // R11

endmodule

bind tile_fetch_agen tfa_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pix_valid    (pix_valid),
    .lyr_en       (lyr_en),
    .bmp_mode     (bmp_mode),
    .attr_from_reg(attr_from_reg),
    .map_rd_en    (map_rd_en),
    .attr_rd_en   (attr_rd_en),
    .map_rdata    (map_rdata),
    .out_valid    (out_valid),
    .out_transp   (out_transp),
    .out_data_addr(out_data_addr),
    .out_bit_ofs  (out_bit_ofs)
);

// File: tb/tile_fetch_agen_tb.sv
module tile_fetch_agen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_valid = 1'b0;
    logic [8:0]  beam_x = '0, beam_y = '0, line_xofs = '0, scroll_x = '0, scroll_y = '0;
    logic [11:0] lyr_attr = '0;
    logic        lyr_en = 1'b1, bmp_mode = 1'b0, attr_from_reg = 1'b1, wallpaper = 1'b0;
    logic        line_scroll_en = 1'b0, blend_en = 1'b0;
    logic [12:0] map_base = '0, attr_base = '0;
    logic [15:0] tile_seg = '0;
    logic        map_rd_en, attr_rd_en;
    logic [12:0] map_addr, attr_addr;
    logic [15:0] map_rdata = '0, attr_rdata = '0;
    logic        out_valid, out_transp, out_hflip, out_vflip, out_blend;
    logic [28:0] out_data_addr;
    logic [3:0]  out_bit_ofs, out_pal;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  force_zero = 1'b0;
    int  salt = 32'h1234;

    always #4 clk = ~clk;

    tile_fetch_agen u_dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid),
        .beam_x(beam_x), .beam_y(beam_y), .line_xofs(line_xofs),
        .scroll_x(scroll_x), .scroll_y(scroll_y), .lyr_attr(lyr_attr),
        .lyr_en(lyr_en), .bmp_mode(bmp_mode), .attr_from_reg(attr_from_reg),
        .wallpaper(wallpaper), .line_scroll_en(line_scroll_en), .blend_en(blend_en),
        .map_base(map_base), .attr_base(attr_base), .tile_seg(tile_seg),
        .map_rd_en(map_rd_en), .map_addr(map_addr), .map_rdata(map_rdata),
        .attr_rd_en(attr_rd_en), .attr_addr(attr_addr), .attr_rdata(attr_rdata),
        .out_valid(out_valid), .out_transp(out_transp), .out_data_addr(out_data_addr),
        .out_bit_ofs(out_bit_ofs), .out_pal(out_pal), .out_hflip(out_hflip),
        .out_vflip(out_vflip), .out_blend(out_blend)
    );

    function automatic logic [15:0] map_fn(int a);
        if (force_zero) return 16'd0;
        return 16'(((a * 32'h9E37) + salt) >>> 3);
    endfunction

    function automatic logic [15:0] attr_fn(int a);
        return 16'((a * 32'h6F4B) ^ salt);
    endfunction

    // synchronous memory model: answer one cycle after the strobe
    always @(posedge clk) begin
        if (map_rd_en)  map_rdata  <= map_fn(int'(map_addr));
        if (attr_rd_en) attr_rdata <= attr_fn(int'(attr_addr));
    end

    task automatic chk(input string req, input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    task automatic run_pixel(input string tag, input int bx, input int by, input int lo);
        int bppn, w, h, lx, ly, lin, maddr, aaddr, odd, tx, ty, bitp, idx, byt, aw;
        int pal, hf, vf, bl;
        longint daddr;
        bit live, tr;
        bppn  = 2 * int'(lyr_attr[1:0]) + 2;
        w     = 8 << lyr_attr[5:4];
        h     = 8 << lyr_attr[7:6];
        lx    = (bx + int'(scroll_x) + (line_scroll_en ? lo : 0)) % 512;
        ly    = (by + int'(scroll_y)) % 256;
        lin   = (ly / h) * (512 / w) + lx / w;
        maddr = (int'(map_base) + lin) % 8192;
        aaddr = wallpaper ? int'(attr_base) : (int'(attr_base) + lin / 2) % 8192;
        odd   = wallpaper ? 0 : lin % 2;
        live  = lyr_en && !bmp_mode;
        idx   = int'(map_fn(maddr));
        aw    = int'(attr_fn(aaddr));
        byt   = odd ? (aw >> 8) & 255 : aw & 255;
        if (attr_from_reg) begin
            pal = int'(lyr_attr[11:8]); hf = int'(lyr_attr[2]);
            vf  = int'(lyr_attr[3]);    bl = int'(blend_en);
        end else begin
            pal = byt & 15; hf = (byt >> 4) & 1; vf = (byt >> 5) & 1; bl = (byt >> 6) & 1;
        end
        tx = lx % w; ty = ly % h;
        if (hf != 0) tx = w - 1 - tx;
        if (vf != 0) ty = h - 1 - ty;
        bitp  = (ty * w + tx) * bppn;
        daddr = longint'(tile_seg) * 64 + longint'(idx) * (w * h * bppn / 16) + bitp / 16;
        tr    = !live || idx == 0;

        beam_x = 9'(bx); beam_y = 9'(by); line_xofs = 9'(lo); pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        chk(live ? "R2" : "R11", tag, longint'(map_rd_en), longint'(live));
        chk(live ? "R5" : "R11", tag, longint'(attr_rd_en), longint'(live && !attr_from_reg));
        if (live) chk("R2", tag, longint'(map_addr), maddr);
        if (live && !attr_from_reg) chk(wallpaper ? "R6" : "R4", tag, longint'(attr_addr), aaddr);
        @(negedge clk);
        chk("R7", tag, longint'(out_valid), 0);
        @(negedge clk);
        chk("R7", tag, longint'(out_valid), 1);
        chk(live ? "R10" : "R11", tag, longint'(out_transp), longint'(tr));
        if (tr) begin
            chk("R10", tag, longint'(out_data_addr), 0);
            chk("R10", tag, longint'({out_bit_ofs, out_pal, out_hflip, out_vflip, out_blend}), 0);
        end else begin
            chk("R7", tag, longint'(out_data_addr), daddr);
            chk("R8", tag, longint'(out_bit_ofs), bitp % 16);
            chk(attr_from_reg ? "R5" : "R4", tag, longint'(out_pal), pal);
            chk("R9", tag, longint'(out_hflip), hf);
            chk("R9", tag, longint'(out_vflip), vf);
            chk(attr_from_reg ? "R5" : "R4", tag, longint'(out_blend), bl);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        // R1: quiet during and right after reset
        chk("R1", "reset", longint'({out_valid, map_rd_en, attr_rd_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "post-reset", longint'({out_valid, map_rd_en, attr_rd_en}), 0);

        // basic 8x8 4bpp, register attributes
        lyr_attr = 12'h5_0_1; tile_seg = 16'h0102; map_base = 13'h0100; blend_en = 1'b1;
        run_pixel("basic", 10, 20, 0);
        // R2 wrap of plane width
        scroll_x = 9'd40;
        run_pixel("R2 wrap", 500, 7, 0);
        scroll_x = 9'd0;
        // R3 line scroll enabled and then ignored
        line_scroll_en = 1'b1;
        run_pixel("R3 on", 30, 3, 100);
        line_scroll_en = 1'b0;
        run_pixel("R3 off", 30, 3, 100);
        // R4 attribute map, even and odd tiles
        attr_from_reg = 1'b0; attr_base = 13'h0400;
        run_pixel("R4 even", 0, 0, 0);
        run_pixel("R4 odd", 8, 0, 0);
        // R6 wallpaper forces first attribute on an odd tile
        wallpaper = 1'b1;
        run_pixel("R6 wall", 8, 9, 0);
        wallpaper = 1'b0; attr_from_reg = 1'b1;
        // R8 6bpp straddling words
        lyr_attr = 12'h0_0_2;
        run_pixel("R8 ofs12", 2, 0, 0);
        run_pixel("R8 ofs2", 3, 0, 0);
        run_pixel("R8 ofs14", 5, 1, 0);
        // R9 mirroring in 64x64 tiles
        lyr_attr = 12'h3_F_F;
        run_pixel("R9 both", 70, 5, 0);
        lyr_attr = 12'h3_F_7;
        run_pixel("R9 h", 3, 200, 0);
        // R10 zero index
        force_zero = 1'b1;
        run_pixel("R10 zero", 17, 33, 0);
        force_zero = 1'b0;
        // R11 disabled and bitmap mode
        lyr_en = 1'b0;
        run_pixel("R11 off", 17, 33, 0);
        lyr_en = 1'b1; bmp_mode = 1'b1;
        run_pixel("R11 bmp", 17, 33, 0);
        bmp_mode = 1'b0;

        for (int i = 0; i < 400; i++) begin
            lyr_attr       = 12'($urandom);
            attr_from_reg  = 1'($urandom);
            wallpaper      = ($urandom % 8) == 0;
            line_scroll_en = 1'($urandom);
            blend_en       = 1'($urandom);
            scroll_x       = 9'($urandom);
            scroll_y       = 9'($urandom);
            map_base       = 13'($urandom);
            attr_base      = 13'($urandom);
            tile_seg       = 16'($urandom);
            salt           = int'($urandom);
            force_zero     = ($urandom % 16) == 0;
            lyr_en         = ($urandom % 16) != 0;
            run_pixel("random", int'($urandom % 512), int'($urandom % 512), int'($urandom % 512));
        end
        finish_run();
    end

endmodule